// File: doc/BRIEF.md
# Base Address Register Pair

This block is the device side of a base address register in a configuration header. It holds either a single 32-bit slot or two neighbouring slots that together carry a 64-bit base. Configuration software writes and reads whole dwords, one slot at a time. The low bits of the first slot are fixed by parameters and report what kind of region the register claims: memory or I/O space, 32- or 64-bit placement, and whether prefetching is allowed. No write can change these bits.

The region size is a power of two set by a parameter. Every address bit below that size is tied to zero. When host software writes all ones to the slot and reads it back, it gets the size mask, and from that it works out how large the region is. It then writes back the value it saved before, or a freshly assigned base. If the implement parameter is cleared, the slot reads as zero and ignores every write, so software treats it as absent.

The stored base also appears on a 64-bit output for the device's own decode logic. That decode logic is not part of this block. Parameter combinations that are not legal are rejected at elaboration: an I/O register cannot be 64-bit, a memory region must be at least 16 bytes, an I/O region must be at least 4 bytes, and a 32-bit region can be at most 2^31 bytes.

Top module: `bar_pair`

## Requirements
- R1: An I/O register reads 1 in bit 0 of the low slot and 0 in bit 1. A memory register reads 0 in bit 0.
- R2: For a memory register, bits [2:1] of the low slot read 2'b10 when it is 64-bit and 2'b00 when it is 32-bit. Bit 3 reads 1 exactly when it is prefetchable.
- R3: Writes never change the fixed low bits: [3:0] for memory and [1:0] for I/O. Whatever the written data, those bits read back as their type value.
- R4: After all ones is written to the low slot, a read of that slot returns ones in bits [31:SIZE_LOG2] and zeros in the address bits below SIZE_LOG2, combined by OR with the type bits.
- R5: In a 64-bit register, the high slot (cfg_wr_hi=1, cfg_rd_hi=1) holds base bits [63:32]. After all ones is written to it, it reads back ones above the size boundary and zeros below it.
- R6: When BAR_EN=0, both slots read all zeros, base_addr stays zero, and writes have no effect.
- R7: When the register is 32-bit, the high slot reads zero and writes to it change neither the read data nor base_addr.
- R8: A write to a slot stores the written data with the size-masked bits and the type bits cleared. A later read returns that stored value combined by OR with the type bits.
- R9: Reset clears every writable address bit to zero.
- R10: base_addr gives {high slot address bits, low slot address bits}, with the type bits as zero. It changes only on the clock edge that follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Dword configuration write strobe |
| cfg_wr_hi | input | 1 | Write slot select: 0 is the low slot, 1 is the high slot |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_hi | input | 1 | Read slot select: 0 is the low slot, 1 is the high slot |
| cfg_rdata | output | 32 | Read data for the selected slot, combinational |
| base_addr | output | 64 | Current base address, type bits as zero |

## Verification
Four instances share one write bus: a 64-bit prefetchable memory register, a small I/O register, a 32-bit memory register and a disabled register. The same data therefore shows, in a single step, how each variant masks it differently. All-ones writes to each slot separate the size mask from the type bits. Data with the low nibble set checks that the fixed bits cannot be written. Seeded random values, about one in five of them all ones, are interleaved across both slots. Together they check that each slot keeps its own value and that writing one slot never disturbs the other. A reset in the middle of the run checks that the stored bases clear.

// File: rtl/bar_pair_pkg.sv
package bar_pair_pkg;

   // Ones at and above bit position lg: the writable part of a sized base.
   function automatic logic [63:0] size_mask(int unsigned lg);
      return ~64'h0 << lg;
   endfunction

   // Fixed low nibble of the first slot.
   function automatic logic [3:0] type_nibble(bit en, bit io, bit w64, bit pf);
      logic [3:0] t;
      if (!en)     t = 4'h0;
      else if (io) t = 4'b0001;
      else         t = {pf, w64, 2'b00};
      return t;
   endfunction

endpackage

// File: rtl/bar_addr_slot.sv
module bar_addr_slot #(
   parameter logic [31:0] WMASK = 32'hFFFF_FFF0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] q
);

   generate
      if (WMASK == 32'h0) begin : g_tied
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, wr_en, wr_data};
         assign q = 32'h0;
      end else begin : g_reg
         logic [31:0] addr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     addr_q <= 32'h0;
            else if (wr_en) addr_q <= wr_data & WMASK;
         end
         assign q = addr_q;
      end
   endgenerate

endmodule

// File: rtl/bar_read_mux.sv
module bar_read_mux (
   input  logic        rd_hi,
   input  logic [31:0] lo_q,
   input  logic [31:0] hi_q,
   input  logic [3:0]  type_lo,
   output logic [31:0] rdata
);

   always_comb begin
      if (rd_hi) rdata = hi_q;
      else       rdata = lo_q | {28'h0, type_lo};
   end

endmodule

// File: rtl/bar_pair.sv
module bar_pair
   import bar_pair_pkg::*;
#(
   parameter bit          BAR_EN    = 1'b1,
   parameter bit          SPACE_IO  = 1'b0,
   parameter bit          WIDE64    = 1'b1,
   parameter bit          PREFETCH  = 1'b1,
   parameter int unsigned SIZE_LOG2 = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic        cfg_wr_hi,
   input  logic [31:0] cfg_wdata,
   input  logic        cfg_rd_hi,
   output logic [31:0] cfg_rdata,
   output logic [63:0] base_addr
);

   localparam int unsigned INFO_W    = SPACE_IO ? 2 : 4;
   localparam logic [63:0] SZ_MASK   = size_mask(SIZE_LOG2);
   localparam logic [31:0] INFO_MASK = ~((32'd1 << INFO_W) - 32'd1);
   localparam logic [31:0] LO_WMASK  = BAR_EN ? (SZ_MASK[31:0] & INFO_MASK) : 32'h0;
   localparam logic [31:0] HI_WMASK  = (BAR_EN && WIDE64) ? SZ_MASK[63:32] : 32'h0;
   localparam logic [3:0]  TYPE_LO   = type_nibble(BAR_EN, SPACE_IO, WIDE64, PREFETCH);

   // Elaboration-time parameter checks
   generate
      if (SPACE_IO && WIDE64) begin : g_bad_io64
         $error("bar_pair: I/O space cannot be 64-bit");
      end
      if (!SPACE_IO && SIZE_LOG2 < 4) begin : g_bad_mem_size
         $error("bar_pair: memory region below 16 bytes");
      end
      if (SPACE_IO && SIZE_LOG2 < 2) begin : g_bad_io_size
         $error("bar_pair: I/O region below 4 bytes");
      end
      if (!WIDE64 && SIZE_LOG2 > 31) begin : g_bad_32_size
         $error("bar_pair: 32-bit region too large");
      end
      if (SIZE_LOG2 > 63) begin : g_bad_64_size
         $error("bar_pair: 64-bit region too large");
      end
   endgenerate

   logic        wr_lo_en;
   logic        wr_hi_en;
   logic [31:0] lo_q;
   logic [31:0] hi_q;

   assign wr_lo_en = cfg_wr & ~cfg_wr_hi;
   assign wr_hi_en = cfg_wr &  cfg_wr_hi;

   bar_addr_slot #(.WMASK(LO_WMASK)) u_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_lo_en),
      .wr_data (cfg_wdata),
      .q       (lo_q)
   );

   bar_addr_slot #(.WMASK(HI_WMASK)) u_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_hi_en),
      .wr_data (cfg_wdata),
      .q       (hi_q)
   );

   bar_read_mux u_mux (
      .rd_hi   (cfg_rd_hi),
      .lo_q    (lo_q),
      .hi_q    (hi_q),
      .type_lo (TYPE_LO),
      .rdata   (cfg_rdata)
   );

   assign base_addr = {hi_q, lo_q};

endmodule

// File: rtl/bar_pair_chk.sv
module bar_pair_chk
   import bar_pair_pkg::*;
#(
   parameter bit          BAR_EN    = 1'b1,
   parameter bit          SPACE_IO  = 1'b0,
   parameter bit          WIDE64    = 1'b1,
   parameter bit          PREFETCH  = 1'b1,
   parameter int unsigned SIZE_LOG2 = 20
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_wr,
   input logic        cfg_wr_hi,
   input logic [31:0] cfg_wdata,
   input logic        cfg_rd_hi,
   input logic [31:0] cfg_rdata,
   input logic [63:0] base_addr
);

   localparam logic [63:0] SZ_MASK = size_mask(SIZE_LOG2);
   localparam logic [31:0] LO_KEEP = BAR_EN ? (SZ_MASK[31:0] & (SPACE_IO ? ~32'h3 : ~32'hF)) : 32'h0;
   localparam logic [31:0] HI_KEEP = (BAR_EN && WIDE64) ? SZ_MASK[63:32] : 32'h0;
   localparam logic [3:0]  TYPE_LO = type_nibble(BAR_EN, SPACE_IO, WIDE64, PREFETCH);

   // R1, R2, R3: fixed low bits of the first slot
   assert_type_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd_hi |-> cfg_rdata[3:0] == TYPE_LO);

   // R8: low slot stores masked write data
   assert_lo_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_wr_hi) |=> base_addr[31:0] == ($past(cfg_wdata) & LO_KEEP));

   // R5, R7: high slot stores masked data, or nothing when 32-bit
   assert_hi_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wr_hi) |=> base_addr[63:32] == ($past(cfg_wdata) & HI_KEEP));

   // R10: base moves only after a write
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(base_addr));

   // R4: bits below the size boundary stay zero
   assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (base_addr[31:0] & ~LO_KEEP) == 32'h0);

   // R6: a disabled register keeps a zero base
   assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (BAR_EN == 1'b0) |-> base_addr == 64'h0);

endmodule

bind bar_pair bar_pair_chk #(
   .BAR_EN    (BAR_EN),
   .SPACE_IO  (SPACE_IO),
   .WIDE64    (WIDE64),
   .PREFETCH  (PREFETCH),
   .SIZE_LOG2 (SIZE_LOG2)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_wr_hi (cfg_wr_hi),
   .cfg_wdata (cfg_wdata),
   .cfg_rd_hi (cfg_rd_hi),
   .cfg_rdata (cfg_rdata),
   .base_addr (base_addr)
);

// File: tb/bar_pair_bench.sv
module bar_pair_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int N = 4;
   // 0: 64-bit prefetchable memory, 1: I/O, 2: 32-bit memory, 3: disabled
   localparam bit          CFG_EN  [N] = '{1'b1, 1'b1, 1'b1, 1'b0};
   localparam bit          CFG_IO  [N] = '{1'b0, 1'b1, 1'b0, 1'b0};
   localparam bit          CFG_W64 [N] = '{1'b1, 1'b0, 1'b0, 1'b1};
   localparam bit          CFG_PF  [N] = '{1'b1, 1'b0, 1'b0, 1'b1};
   localparam int unsigned CFG_SL  [N] = '{20, 5, 12, 20};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic        wr_hi = 1'b0;
   logic        rd_hi = 1'b0;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata [N];
   logic [63:0] base  [N];
   logic [63:0] model [N];
   int          checks = 0;
   int          fails = 0;

   always #2.5 clk = ~clk;

   bar_pair #(.BAR_EN(CFG_EN[0]), .SPACE_IO(CFG_IO[0]), .WIDE64(CFG_W64[0]),
              .PREFETCH(CFG_PF[0]), .SIZE_LOG2(CFG_SL[0])) u_bar_pair (
      .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_wr_hi(wr_hi), .cfg_wdata(wdata),
      .cfg_rd_hi(rd_hi), .cfg_rdata(rdata[0]), .base_addr(base[0]));

   bar_pair #(.BAR_EN(CFG_EN[1]), .SPACE_IO(CFG_IO[1]), .WIDE64(CFG_W64[1]),
              .PREFETCH(CFG_PF[1]), .SIZE_LOG2(CFG_SL[1])) u_bar_pair_io (
      .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_wr_hi(wr_hi), .cfg_wdata(wdata),
      .cfg_rd_hi(rd_hi), .cfg_rdata(rdata[1]), .base_addr(base[1]));

   bar_pair #(.BAR_EN(CFG_EN[2]), .SPACE_IO(CFG_IO[2]), .WIDE64(CFG_W64[2]),
              .PREFETCH(CFG_PF[2]), .SIZE_LOG2(CFG_SL[2])) u_bar_pair_m32 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_wr_hi(wr_hi), .cfg_wdata(wdata),
      .cfg_rd_hi(rd_hi), .cfg_rdata(rdata[2]), .base_addr(base[2]));

   bar_pair #(.BAR_EN(CFG_EN[3]), .SPACE_IO(CFG_IO[3]), .WIDE64(CFG_W64[3]),
              .PREFETCH(CFG_PF[3]), .SIZE_LOG2(CFG_SL[3])) u_bar_pair_off (
      .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_wr_hi(wr_hi), .cfg_wdata(wdata),
      .cfg_rd_hi(rd_hi), .cfg_rdata(rdata[3]), .base_addr(base[3]));

   // Writable bits for instance k, derived from the requirements
   function automatic logic [63:0] wmask(int k);
      logic [63:0] m;
      m = ~64'h0 << CFG_SL[k];
      m &= CFG_IO[k] ? ~64'h3 : ~64'hF;
      if (!CFG_W64[k]) m[63:32] = 32'h0;
      if (!CFG_EN[k])  m = 64'h0;
      return m;
   endfunction

   function automatic logic [31:0] tbits(int k);
      if (!CFG_EN[k])     return 32'h0;
      else if (CFG_IO[k]) return 32'h1;
      else                return {28'h0, CFG_PF[k], CFG_W64[k], 2'b00};
   endfunction

   function automatic logic [31:0] exp_rd(int k, bit hi);
      return hi ? model[k][63:32] : (model[k][31:0] | tbits(k));
   endfunction

   task automatic compare(string tag, string what, int k, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s dut%0d %s: actual %h expected %h", tag, k, what, act, exp);
      end
   endtask

   task automatic check_dut(int k, string tag);
      rd_hi = 1'b0;
      #0.5;
      compare(tag, "low slot", k, {32'h0, rdata[k]}, {32'h0, exp_rd(k, 1'b0)});
      rd_hi = 1'b1;
      #0.5;
      compare(tag, "high slot", k, {32'h0, rdata[k]}, {32'h0, exp_rd(k, 1'b1)});
      rd_hi = 1'b0;
      compare(tag, "base", k, base[k], model[k]);
   endtask

   task automatic cfg_write(bit hi, logic [31:0] d);
      @(negedge clk);
      wr = 1'b1;
      wr_hi = hi;
      wdata = d;
      @(negedge clk);
      wr = 1'b0;
      for (int k = 0; k < N; k++) begin
         logic [63:0] m;
         m = wmask(k);
         if (hi) model[k][63:32] = d & m[63:32];
         else    model[k][31:0]  = d & m[31:0];
      end
      #0.2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < N; k++) model[k] = 64'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.2;
      // R9 reset state, R1/R2 type bits visible with zero base
      for (int k = 0; k < N; k++) check_dut(k, "R9");

      // Sizing the low slot with all ones
      cfg_write(1'b0, 32'hFFFF_FFFF);
      check_dut(0, "R4");
      check_dut(1, "R1");
      check_dut(2, "R2");
      check_dut(3, "R6");

      // Sizing the high slot
      cfg_write(1'b1, 32'hFFFF_FFFF);
      check_dut(0, "R5");
      check_dut(2, "R7");
      check_dut(3, "R6");

      // Attempt to overwrite the fixed bits
      cfg_write(1'b0, 32'h1234_567F);
      for (int k = 0; k < N; k++) check_dut(k, "R3");
      cfg_write(1'b0, 32'h0000_0006);
      for (int k = 0; k < N; k++) check_dut(k, "R3");

      // Restore a saved base
      cfg_write(1'b0, 32'hCAFE_0000);
      cfg_write(1'b1, 32'h0000_0001);
      for (int k = 0; k < N; k++) check_dut(k, "R8");
      compare("R10", "base 64", 0, base[0], 64'h0000_0001_CAF0_0000);

      // Seeded random mix
      void'($urandom(32'd2024));
      for (int i = 0; i < 80; i++) begin
         logic [31:0] d;
         bit          h;
         d = (($urandom % 5) == 0) ? 32'hFFFF_FFFF : $urandom;
         h = 1'($urandom % 2);
         cfg_write(h, d);
         for (int k = 0; k < N; k++) check_dut(k, "R8");
      end

      // Reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < N; k++) model[k] = 64'h0;
      #0.2;
      for (int k = 0; k < N; k++) check_dut(k, "R9");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule